// File: doc/BRIEF.md
# Two-Way Cache Way-Steering Predictor

This block picks the way a new line is written into in a two-way set-associative cache, and the way a lookup should probe first, so that most lookups touch only one tag location. The probe-first choice is derived from the line address itself. Because install and prediction both follow the same address-based "home way", no per-set prediction state is kept.

On an install the block receives a line address and a flag saying the home way holds a line worth keeping. It returns the way to fill. Normally that is the home way. Under a conflict a pseudo-random draw sometimes redirects the line to the other way. A small direct-mapped table remembers, per 16-line address region, the way the most recent install in that region went to. Later installs and lookups in the region follow that remembered way.

After the cache controller probes the predicted way, it reports hit or miss. On a miss the block requests one more probe of the opposite way. Two saturating counters tally first-probe hits and second-probe requests.

Top module: `way_steer_top`

## Requirements
- R1: The home way of a line address is the XOR of address bits [17:10] (with defaults). A lookup whose region has no matching table entry predicts the home way.
- R2: An install with no matching region entry and `inst_conflict` low is given the home way.
- R3: An install with no matching region entry and `inst_conflict` high goes to the opposite way exactly when the low 3 bits of a 16-bit LFSR are all zero. Otherwise it goes to the home way. The LFSR is a right-shifting Galois register with mask 0xB400: next = (s>>1) XOR (s[0] ? 0xB400 : 0). It advances once per install request, and each install uses the state held before its own advance.
- R4: An install whose region matches a valid table entry takes the way stored in that entry, regardless of `inst_conflict` and the LFSR.
- R5: A lookup whose region matches a valid table entry predicts the stored way.
- R6: The region table is direct-mapped. Its index is address bits [9:4] and its tag is bits [41:10]. Every install writes its entry with the chosen way, replacing any entry with a different tag. A lookup in a replaced region falls back to the home way.
- R7: One cycle after a probe report with `probe_hit` low, `second_req` is high for one cycle and `second_way` is the inverse of the reported `probe_way`. A probe report with `probe_hit` high produces no second request.
- R8: `first_hit_cnt` counts hit reports and `second_cnt` counts miss reports. Each counter stops at its all-ones value.
- R9: `inst_way_valid` and `pred_valid` rise exactly one cycle after `inst_valid` and `look_valid` respectively, and never otherwise.
- R10: Synchronous active-high reset invalidates every table entry, loads the LFSR with 0xACE1, clears both counters and drives every valid output low.
- R11: When an install and a lookup are presented in the same cycle, the lookup sees the table as it was before that install.

Ports table follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | Install request |
| inst_addr | input | ADDR_W | Line address being installed |
| inst_conflict | input | 1 | Home way holds a recently used line |
| inst_way_valid | output | 1 | Install way result valid |
| inst_way | output | 1 | Way to fill |
| look_valid | input | 1 | Lookup request |
| look_addr | input | ADDR_W | Line address being looked up |
| pred_valid | output | 1 | Prediction valid |
| pred_way | output | 1 | Way to probe first |
| probe_valid | input | 1 | First-probe result report |
| probe_hit | input | 1 | First probe hit |
| probe_way | input | 1 | Way that was probed |
| second_req | output | 1 | Probe the other way |
| second_way | output | 1 | Way for the second probe |
| first_hit_cnt | output | CNT_W | Saturating first-probe hit count |
| second_cnt | output | CNT_W | Saturating second-probe count |

## Verification
An install and a lookup can land in the same cycle. They share the region table, with the install writing the entry that the lookup reads. The bench presents them together on the same region, on a region whose entry the install is about to replace, and on a region with no entry yet. It expects the prediction from the table contents before the write. A lookup in the following cycle must then reflect the newly written way.

// File: rtl/way_steer_pkg.sv
package way_steer_pkg;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
    localparam int DRAW_BITS = 3;

    typedef enum logic [1:0] {
        SRC_HOME = 2'd0,
        SRC_ALT  = 2'd1,
        SRC_GANG = 2'd2
    } steer_src_t;

    typedef struct packed {
        logic       way;
        steer_src_t src;
    } steer_pick_t;

    typedef struct packed {
        logic vld;
        logic way;
    } way_res_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
    endfunction

    function automatic steer_pick_t pick_install(input logic gang_hit, input logic gang_way,
                                                 input logic home, input logic conflict,
                                                 input logic draw_zero);
        steer_pick_t p;
        if (gang_hit) begin
            p.way = gang_way;
            p.src = SRC_GANG;
        end else if (conflict && draw_zero) begin
            p.way = ~home;
            p.src = SRC_ALT;
        end else begin
            p.way = home;
            p.src = SRC_HOME;
        end
        return p;
    endfunction

endpackage

// File: rtl/ws_lfsr.sv
module ws_lfsr
    import way_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [LFSR_W-1:0] state
);
    logic [LFSR_W-1:0] s_q;

    always_ff @(posedge clk) begin
        if (rst)
            s_q <= LFSR_SEED;
        else if (adv)
            s_q <= lfsr_step(s_q);
    end

    assign state = s_q;
endmodule

// File: rtl/ws_region_table.sv
module ws_region_table #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [TAG_W-1:0] rd_a_tag,
    output logic             rd_a_hit,
    output logic             rd_a_way,
    input  logic [IDX_W-1:0] rd_b_idx,
    input  logic [TAG_W-1:0] rd_b_tag,
    output logic             rd_b_hit,
    output logic             rd_b_way,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_way
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] way_q;
    logic [TAG_W-1:0] tag_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)
            vld_q <= '0;
        else if (wr_en)
            vld_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            way_q[wr_idx] <= wr_way;
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_a_hit = vld_q[rd_a_idx] && (tag_q[rd_a_idx] == rd_a_tag);
    assign rd_a_way = way_q[rd_a_idx];
    assign rd_b_hit = vld_q[rd_b_idx] && (tag_q[rd_b_idx] == rd_b_tag);
    assign rd_b_way = way_q[rd_b_idx];
endmodule

// File: rtl/ws_probe_track.sv
module ws_probe_track #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             probe_valid,
    input  logic             probe_hit,
    input  logic             probe_way,
    output logic             second_req,
    output logic             second_way,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             req_q, way_q;
    logic [CNT_W-1:0] hit_q, miss_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            way_q  <= 1'b0;
            hit_q  <= '0;
            miss_q <= '0;
        end else begin
            req_q <= probe_valid && !probe_hit;
            if (probe_valid && !probe_hit)
                way_q <= ~probe_way;
            if (probe_valid && probe_hit && hit_q != CNT_MAX)
                hit_q <= hit_q + 1'b1;
            if (probe_valid && !probe_hit && miss_q != CNT_MAX)
                miss_q <= miss_q + 1'b1;
        end
    end

    assign second_req = req_q;
    assign second_way = way_q;
    assign hit_cnt    = hit_q;
    assign miss_cnt   = miss_q;
endmodule

// File: rtl/way_steer_top.sv
module way_steer_top
    import way_steer_pkg::*;
#(
    parameter int ADDR_W      = 42,
    parameter int REGION_BITS = 4,
    parameter int RT_IDX_W    = 6,
    parameter int SET_BITS    = 10,
    parameter int HOME_BITS   = 8,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inst_valid,
    input  logic [ADDR_W-1:0] inst_addr,
    input  logic              inst_conflict,
    output logic              inst_way_valid,
    output logic              inst_way,
    input  logic              look_valid,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              pred_valid,
    output logic              pred_way,
    input  logic              probe_valid,
    input  logic              probe_hit,
    input  logic              probe_way,
    output logic              second_req,
    output logic              second_way,
    output logic [CNT_W-1:0]  first_hit_cnt,
    output logic [CNT_W-1:0]  second_cnt
);
    localparam int RT_TAG_W = ADDR_W - REGION_BITS - RT_IDX_W;
    localparam int TAG_LSB  = REGION_BITS + RT_IDX_W;

    logic [LFSR_W-1:0] lfsr_state;
    logic [RT_IDX_W-1:0] i_idx, l_idx;
    logic [RT_TAG_W-1:0] i_tag, l_tag;
    logic i_hit, i_gway, l_hit, l_gway;
    logic i_home, l_home;
    steer_pick_t i_pick;
    way_res_t inst_q, pred_q;
    logic unused_low_bits;

    assign unused_low_bits = ^{inst_addr[REGION_BITS-1:0], look_addr[REGION_BITS-1:0]};

    assign i_idx  = inst_addr[REGION_BITS +: RT_IDX_W];
    assign i_tag  = inst_addr[TAG_LSB +: RT_TAG_W];
    assign l_idx  = look_addr[REGION_BITS +: RT_IDX_W];
    assign l_tag  = look_addr[TAG_LSB +: RT_TAG_W];
    assign i_home = ^inst_addr[SET_BITS +: HOME_BITS];
    assign l_home = ^look_addr[SET_BITS +: HOME_BITS];

    ws_lfsr lfsr_i (
        .clk  (clk),
        .rst  (rst),
        .adv  (inst_valid),
        .state(lfsr_state)
    );

    ws_region_table #(.IDX_W(RT_IDX_W), .TAG_W(RT_TAG_W)) rt_i (
        .clk     (clk),
        .rst     (rst),
        .rd_a_idx(i_idx),
        .rd_a_tag(i_tag),
        .rd_a_hit(i_hit),
        .rd_a_way(i_gway),
        .rd_b_idx(l_idx),
        .rd_b_tag(l_tag),
        .rd_b_hit(l_hit),
        .rd_b_way(l_gway),
        .wr_en   (inst_valid),
        .wr_idx  (i_idx),
        .wr_tag  (i_tag),
        .wr_way  (i_pick.way)
    );

    assign i_pick = pick_install(i_hit, i_gway, i_home, inst_conflict,
                                 lfsr_state[DRAW_BITS-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            inst_q <= '0;
            pred_q <= '0;
        end else begin
            inst_q.vld <= inst_valid;
            if (inst_valid)
                inst_q.way <= i_pick.way;
            pred_q.vld <= look_valid;
            if (look_valid)
                pred_q.way <= l_hit ? l_gway : l_home;
        end
    end

    assign inst_way_valid = inst_q.vld;
    assign inst_way       = inst_q.way;
    assign pred_valid     = pred_q.vld;
    assign pred_way       = pred_q.way;

    ws_probe_track #(.CNT_W(CNT_W)) probe_i (
        .clk        (clk),
        .rst        (rst),
        .probe_valid(probe_valid),
        .probe_hit  (probe_hit),
        .probe_way  (probe_way),
        .second_req (second_req),
        .second_way (second_way),
        .hit_cnt    (first_hit_cnt),
        .miss_cnt   (second_cnt)
    );
endmodule

// File: rtl/way_steer_chk.sv
module way_steer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             inst_valid,
    input logic             inst_way_valid,
    input logic             look_valid,
    input logic             pred_valid,
    input logic             probe_valid,
    input logic             probe_hit,
    input logic             probe_way,
    input logic             second_req,
    input logic             second_way,
    input logic [CNT_W-1:0] first_hit_cnt,
    input logic [CNT_W-1:0] second_cnt,
    input logic [15:0]      lfsr_state
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    assert_inst_latency_R9: assert property (@(posedge clk) disable iff (rst)
        inst_way_valid |-> $past(inst_valid));
    assert_pred_latency_R9: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> $past(look_valid));
    assert_second_cause_R7: assert property (@(posedge clk) disable iff (rst)
        second_req |-> $past(probe_valid && !probe_hit));
    assert_second_other_way_R7: assert property (@(posedge clk) disable iff (rst)
        second_req |-> (second_way == !$past(probe_way)));
    assert_no_second_on_hit_R7: assert property (@(posedge clk) disable iff (rst)
        (probe_valid && probe_hit) |=> !second_req);
    assert_hit_cnt_mono_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> first_hit_cnt >= $past(first_hit_cnt));
    assert_miss_cnt_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (second_cnt == CMAX) |=> (second_cnt == CMAX));
    assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != 16'h0);
endmodule

bind way_steer_top way_steer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .inst_valid    (inst_valid),
    .inst_way_valid(inst_way_valid),
    .look_valid    (look_valid),
    .pred_valid    (pred_valid),
    .probe_valid   (probe_valid),
    .probe_hit     (probe_hit),
    .probe_way     (probe_way),
    .second_req    (second_req),
    .second_way    (second_way),
    .first_hit_cnt (first_hit_cnt),
    .second_cnt    (second_cnt),
    .lfsr_state    (lfsr_state)
);

// File: tb/way_steer_top_tb_top.sv
`timescale 1ns/1ps
module way_steer_top_tb_top;
    localparam int AW = 42;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inst_valid = 0, inst_conflict = 0, look_valid = 0;
    logic probe_valid = 0, probe_hit = 0, probe_way = 0;
    logic [AW-1:0] inst_addr = '0, look_addr = '0;
    logic inst_way_valid, inst_way, pred_valid, pred_way, second_req, second_way;
    logic [CW-1:0] first_hit_cnt, second_cnt;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    way_steer_top #(.CNT_W(CW)) dut_i (.*);

    typedef struct { logic way; string req; } exp_t;
    exp_t q_inst[$], q_pred[$], q_sec[$];

    bit          m_vld [64];
    logic [31:0] m_tag [64];
    bit          m_way [64];
    logic [15:0] m_lfsr = 16'hACE1;
    int          m_hits = 0, m_miss = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [AW-1:0] mk(input logic [31:0] tag, input logic [5:0] idx,
                                         input logic [3:0] lo);
        return {tag, idx, lo};
    endfunction

    function automatic bit home(input logic [AW-1:0] a);
        return ^a[17:10];
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            exp_t e;
            if (inst_way_valid) begin
                if (q_inst.size() == 0) chk(0, "R9 spurious inst_way_valid", 1, 0);
                else begin e = q_inst.pop_front(); chk(inst_way == e.way, e.req, inst_way, e.way); end
            end
            if (pred_valid) begin
                if (q_pred.size() == 0) chk(0, "R9 spurious pred_valid", 1, 0);
                else begin e = q_pred.pop_front(); chk(pred_way == e.way, e.req, pred_way, e.way); end
            end
            if (second_req) begin
                if (q_sec.size() == 0) chk(0, "R7 spurious second_req", 1, 0);
                else begin e = q_sec.pop_front(); chk(second_way == e.way, e.req, second_way, e.way); end
            end
        end
    end

    // One cycle of stimulus; expectations from the bench's own model.
    task automatic step(input bit iv, input logic [AW-1:0] ia, input bit ic, input string ireq,
                        input bit lv, input logic [AW-1:0] la, input string lreq,
                        input bit pv, input bit ph, input bit pw);
        exp_t e;
        int ii, li;
        bit w;
        @(negedge clk);
        inst_valid = iv; inst_addr = ia; inst_conflict = ic;
        look_valid = lv; look_addr = la;
        probe_valid = pv; probe_hit = ph; probe_way = pw;
        if (lv) begin
            li = int'(la[9:4]);
            e.way = (m_vld[li] && m_tag[li] == la[41:10]) ? m_way[li] : home(la);
            e.req = lreq;
            q_pred.push_back(e);
        end
        if (iv) begin
            ii = int'(ia[9:4]);
            if (m_vld[ii] && m_tag[ii] == ia[41:10]) w = m_way[ii];
            else if (ic && m_lfsr[2:0] == 3'b000) w = ~home(ia);
            else w = home(ia);
            e.way = w; e.req = ireq;
            q_inst.push_back(e);
            m_vld[ii] = 1; m_tag[ii] = ia[41:10]; m_way[ii] = w;
            m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0);
        end
        if (pv) begin
            if (ph) m_hits++;
            else begin
                m_miss++;
                e.way = ~pw; e.req = "R7 second probe way";
                q_sec.push_back(e);
            end
        end
    endtask

    task automatic idle();
        step(0, '0, 0, "", 0, '0, "", 0, 0, 0);
    endtask

    task automatic inst(input logic [AW-1:0] a, input bit c, input string r);
        step(1, a, c, r, 0, '0, "", 0, 0, 0);
    endtask

    task automatic look(input logic [AW-1:0] a, input string r);
        step(0, '0, 0, "", 1, a, r, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!inst_way_valid && !pred_valid && !second_req, "R10 valids low after reset",
            {inst_way_valid, pred_valid, second_req}, 0);
        chk(first_hit_cnt == 0 && second_cnt == 0, "R10 counters cleared",
            first_hit_cnt + second_cnt, 0);

        // R1: empty table, predictions follow home way
        for (int k = 0; k < 8; k++)
            look(mk(32'h0000_0100 + k * 3, 6'(k), 4'(k)), "R10/R1 lookup on empty table predicts home way");

        // R2: installs without conflict in fresh regions
        for (int k = 0; k < 6; k++)
            inst(mk(32'h0000_0200 + k, 6'(k), 4'h0), 0, "R2 install without conflict takes home way");
        // R5: lookups elsewhere in those regions
        for (int k = 0; k < 6; k++)
            look(mk(32'h0000_0200 + k, 6'(k), 4'hF), "R5 lookup follows recorded region way");

        // R3: conflict installs into fresh regions, LFSR draws
        for (int k = 0; k < 16; k++)
            inst(mk(32'h0000_1000 + k * 5, 6'(16 + k), 4'h3), 1, "R3 conflict install uses LFSR draw");
        // R4: another line in same regions, no conflict -> ganged way
        for (int k = 0; k < 16; k++)
            inst(mk(32'h0000_1000 + k * 5, 6'(16 + k), 4'h9), 0, "R4 install follows recorded region way");
        for (int k = 0; k < 16; k++)
            look(mk(32'h0000_1000 + k * 5, 6'(16 + k), 4'h1), "R5 lookup in ganged region");

        // R6: overwrite entries with new tags, old regions fall back
        for (int k = 0; k < 4; k++)
            inst(mk(32'h0000_3001 + k, 6'(16 + k), 4'h0), 1, "R6 replacing install");
        for (int k = 0; k < 4; k++)
            look(mk(32'h0000_1000 + k * 5, 6'(16 + k), 4'h2), "R6 replaced region falls back to home way");

        // R11: same-cycle install and lookup on one region
        for (int k = 0; k < 8; k++) begin
            logic [AW-1:0] a;
            a = mk(32'h0000_5000 + k * 7, 6'(40 + k), 4'h0);
            step(1, a, 1, "R11 install beside lookup", 1, a | 42'h5, "R11 lookup sees table before install", 0, 0, 0);
            look(a | 42'h6, "R11 next lookup sees new entry");
        end
        for (int k = 0; k < 4; k++)
            step(1, mk(32'h0000_6000 + k, 6'(16 + k), 4'h0), 0, "R11 replacing install",
                 1, mk(32'h0000_3001 + k, 6'(16 + k), 4'h4), "R11 lookup before replacement", 0, 0, 0);

        // R7: probe outcomes
        step(0, '0, 0, "", 0, '0, "", 1, 0, 0);
        step(0, '0, 0, "", 0, '0, "", 1, 1, 1);
        step(0, '0, 0, "", 0, '0, "", 1, 0, 1);
        idle();
        idle();
        chk(first_hit_cnt == 4'(m_hits) && second_cnt == 4'(m_miss), "R8 counters track probes",
            first_hit_cnt * 16 + second_cnt, m_hits * 16 + m_miss);

        // R8: saturation
        for (int k = 0; k < 20; k++) step(0, '0, 0, "", 0, '0, "", 1, 1, 0);
        for (int k = 0; k < 17; k++) step(0, '0, 0, "", 0, '0, "", 1, 0, k[0]);
        idle();
        idle();
        chk(first_hit_cnt == 4'hF, "R8 hit counter saturates", first_hit_cnt, 15);
        chk(second_cnt == 4'hF, "R8 miss counter saturates", second_cnt, 15);

        repeat (3) idle();
        chk(q_inst.size() == 0 && q_pred.size() == 0 && q_sec.size() == 0,
            "R9 every request answered", q_inst.size() + q_pred.size() + q_sec.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule